// File: doc/BRIEF.md
# Switchover Phase Slew Controller

This block produces the phase command that a digital clock loop applies whenever its input condition changes. The loop may enter holdover, leave holdover, or move from one input reference to another, and each of these is signalled by a one-cycle strobe. The block turns the measured phase error into the output phase command. It also decides how that command behaves at each such event.

A mode input picks between two behaviours. In build-out (hitless) mode the block stores the gap between the new phase error and the present command in an offset register. It then subtracts that offset from every later error, so the command does not move at the event. In slope-limited mode the offset is dropped and the command walks from where it stands toward the raw phase error. Each update tick moves it by at most a step chosen by a 2-bit code. When the remaining gap fits inside one step, the command snaps onto the target and a settled flag rises.

Build-out is not allowed while external loopback is active. In that case every event is handled as slope-limited, whatever the mode input says. Phase values are treated as modular two's-complement numbers, so the walk always takes the shorter way around.

Top module: `phase_slew_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `phaseCmd` to 0, sets `settled` to 1 and clears the offset register, so that after reset the command equals the phase error with one cycle of delay.
- R2: While `settled` is 1 and no event strobe is high, `phaseCmd` at each edge takes the value `phaseErr - offset`, computed modulo 2^PHASE_W.
- R3: An event in build-out mode (`hitlessMode`=1 and `extLoopback`=0) leaves `phaseCmd` unchanged at that edge, keeps `settled` at 1, and loads the offset with `phaseErr - phaseCmd` sampled in the event cycle.
- R4: An event in slope-limited mode (`hitlessMode`=0) clears the offset, holds `phaseCmd` at that edge, and makes `settled` 0 from that edge on.
- R5: While `settled` is 0, each edge with `tick`=1 moves `phaseCmd` toward the target by exactly 2^`slewCode` LSBs (code 0,1,2,3 gives 1,2,4,8). The sign follows the signed PHASE_W-bit difference, target minus command, taken modulo 2^PHASE_W.
- R6: While `settled` is 0, a tick edge at which the magnitude of that difference is no more than the step sets `phaseCmd` to the target and sets `settled` to 1.
- R7: While `settled` is 0, an edge with `tick`=0 and no event leaves `phaseCmd` and `settled` unchanged.
- R8: When `extLoopback` is 1, an event is handled as in R4 even when `hitlessMode` is 1.
- R9: An event that arrives while `settled` is 0 holds `phaseCmd` at its current value, with no jump. The following walk starts from that value toward the new target.
- R10: The three strobes `evtHoldEnter`, `evtHoldExit` and `evtRefSwitch` have the same effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phaseErr | input | PHASE_W | Measured phase error, two's complement |
| evtHoldEnter | input | 1 | One-cycle strobe: loop enters holdover |
| evtHoldExit | input | 1 | One-cycle strobe: loop leaves holdover |
| evtRefSwitch | input | 1 | One-cycle strobe: loop changes input reference |
| hitlessMode | input | 1 | 1 selects build-out handling, 0 selects slope limiting |
| slewCode | input | 2 | Step per tick is 2^slewCode LSBs |
| extLoopback | input | 1 | External loopback active; forces slope limiting |
| tick | input | 1 | Update tick for the slope-limited walk |
| phaseCmd | output | PHASE_W | Corrected phase command |
| settled | output | 1 | 1 when the command tracks its target directly |

## Verification
The bench sweeps every slew code over gaps of both signs, including gaps of zero, exactly one step, one more than a step, and gaps that cross the wrap point. A design with an off-by-one snap test would take an extra tick or overshoot the target. A design that used an unsigned or wider difference would walk the long way around at the wrap. The ticks are gated on alternate cycles, which would expose a walk that ignores `tick`. Events are fired in the middle of a walk and under loopback with the build-out mode selected: a design that reloads the command at the event would show a jump, and one that ignores the loopback rule would stay settled. Each strobe kind is used in both modes, and the build-out offset is checked with hand-worked numbers after the phase error moves.

// File: rtl/phase_slew_pkg.sv
package phase_slew_pkg;
  localparam int SLEW_CODE_W = 2;

  // strobes from control to datapath; all zero means hold
  typedef struct packed {
    logic captureBo;  // load offset with err - cmd
    logic clearBo;    // zero the offset
    logic trackCmd;   // cmd <= target
    logic stepCmd;    // cmd moves one bounded step
  } slewCtlT;
endpackage

// File: rtl/phase_slew_dp.sv
module phase_slew_dp
  import phase_slew_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  slewCtlT                   ctl,
  input  logic [PHASE_W-1:0]        phaseErr,
  input  logic [SLEW_CODE_W-1:0]    slewCode,
  output logic [PHASE_W-1:0]        phaseCmd,
  output logic                      nearTarget
);
  localparam int EXT_W = PHASE_W + 1;

  logic [PHASE_W-1:0] buildOut;
  logic [PHASE_W-1:0] target;
  logic [PHASE_W-1:0] diff;
  logic [EXT_W-1:0]   diffExt;
  logic [EXT_W-1:0]   diffMag;
  logic [EXT_W-1:0]   stepMag;
  logic [PHASE_W-1:0] stepW;
  logic [PHASE_W-1:0] steppedCmd;

  always_comb begin
    target     = phaseErr - buildOut;
    diff       = target - phaseCmd;
    diffExt    = {diff[PHASE_W-1], diff};
    diffMag    = diff[PHASE_W-1] ? (~diffExt + EXT_W'(1)) : diffExt;
    stepMag    = EXT_W'(1) << slewCode;
    stepW      = stepMag[PHASE_W-1:0];
    nearTarget = (diffMag <= stepMag);
    steppedCmd = diff[PHASE_W-1] ? (phaseCmd - stepW) : (phaseCmd + stepW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buildOut <= '0;
    end else if (ctl.captureBo) begin
      buildOut <= phaseErr - phaseCmd;
    end else if (ctl.clearBo) begin
      buildOut <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseCmd <= '0;
    end else if (ctl.trackCmd) begin
      phaseCmd <= target;
    end else if (ctl.stepCmd) begin
      phaseCmd <= steppedCmd;
    end
  end
endmodule

// File: rtl/phase_slew_ctl.sv
module phase_slew_ctl
  import phase_slew_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    evtHoldEnter,
  input  logic    evtHoldExit,
  input  logic    evtRefSwitch,
  input  logic    hitlessMode,
  input  logic    extLoopback,
  input  logic    tick,
  input  logic    nearTarget,
  output slewCtlT ctl,
  output logic    settled
);
  logic slewing;
  logic slewingNext;
  logic anyEvt;
  logic useBuildOut;

  always_comb begin
    anyEvt      = evtHoldEnter | evtHoldExit | evtRefSwitch;
    useBuildOut = hitlessMode & ~extLoopback;
    ctl         = '0;
    slewingNext = slewing;
    if (anyEvt) begin
      if (useBuildOut) begin
        ctl.captureBo = 1'b1;
        slewingNext   = 1'b0;
      end else begin
        ctl.clearBo = 1'b1;
        slewingNext = 1'b1;
      end
    end else if (slewing) begin
      if (tick) begin
        if (nearTarget) begin
          ctl.trackCmd = 1'b1;
          slewingNext  = 1'b0;
        end else begin
          ctl.stepCmd = 1'b1;
        end
      end
    end else begin
      ctl.trackCmd = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) slewing <= 1'b0;
    else     slewing <= slewingNext;
  end

  assign settled = ~slewing;
endmodule

// File: rtl/phase_slew_ctrl.sv
module phase_slew_ctrl
  import phase_slew_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PHASE_W-1:0]     phaseErr,
  input  logic                   evtHoldEnter,
  input  logic                   evtHoldExit,
  input  logic                   evtRefSwitch,
  input  logic                   hitlessMode,
  input  logic [SLEW_CODE_W-1:0] slewCode,
  input  logic                   extLoopback,
  input  logic                   tick,
  output logic [PHASE_W-1:0]     phaseCmd,
  output logic                   settled
);
  slewCtlT ctl;
  logic    nearTarget;

  phase_slew_ctl u_ctl (
    .clk(clk), .rst(rst),
    .evtHoldEnter(evtHoldEnter), .evtHoldExit(evtHoldExit), .evtRefSwitch(evtRefSwitch),
    .hitlessMode(hitlessMode), .extLoopback(extLoopback), .tick(tick),
    .nearTarget(nearTarget), .ctl(ctl), .settled(settled)
  );

  phase_slew_dp #(.PHASE_W(PHASE_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .phaseErr(phaseErr), .slewCode(slewCode),
    .phaseCmd(phaseCmd), .nearTarget(nearTarget)
  );
endmodule

// File: rtl/phase_slew_chk.sv
module phase_slew_chk #(
  parameter int PHASE_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               evtHoldEnter,
  input logic               evtHoldExit,
  input logic               evtRefSwitch,
  input logic               hitlessMode,
  input logic               extLoopback,
  input logic               tick,
  input logic [1:0]         slewCode,
  input logic [PHASE_W-1:0] phaseCmd,
  input logic               settled
);
  logic               anyEvt;
  logic               prevWalk;
  logic [1:0]         prevCode;
  logic [PHASE_W-1:0] prevCmd;
  logic [PHASE_W-1:0] moved;
  logic [PHASE_W:0]   movedExt;
  logic [PHASE_W:0]   movedMag;

  assign anyEvt = evtHoldEnter | evtHoldExit | evtRefSwitch;

  always_ff @(posedge clk) begin
    prevWalk <= !rst && !settled && !anyEvt;
    prevCode <= slewCode;
    prevCmd  <= phaseCmd;
  end

  always_comb begin
    moved    = phaseCmd - prevCmd;
    movedExt = {moved[PHASE_W-1], moved};
    movedMag = moved[PHASE_W-1] ? (~movedExt + 1'b1) : movedExt;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (phaseCmd == '0) && settled); // R1
  AST_HITLESS_HOLD: assert property (@(posedge clk) disable iff (rst)
    anyEvt && hitlessMode && !extLoopback |=> $stable(phaseCmd) && settled); // R3
  AST_SLOPE_UNSETTLE: assert property (@(posedge clk) disable iff (rst)
    anyEvt && !hitlessMode |=> $stable(phaseCmd) && !settled); // R4
  AST_LOOPBACK_FORCE: assert property (@(posedge clk) disable iff (rst)
    anyEvt && extLoopback |=> !settled); // R8
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !settled && !tick && !anyEvt |=> $stable(phaseCmd) && !settled); // R7
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    prevWalk |-> movedMag <= ((PHASE_W+1)'(1) << prevCode)); // R5
endmodule

bind phase_slew_ctrl phase_slew_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst(rst), .evtHoldEnter(evtHoldEnter), .evtHoldExit(evtHoldExit),
  .evtRefSwitch(evtRefSwitch), .hitlessMode(hitlessMode), .extLoopback(extLoopback),
  .tick(tick), .slewCode(slewCode), .phaseCmd(phaseCmd), .settled(settled)
);

// File: tb/test_phase_slew_ctrl.sv
`timescale 1ns/1ps
module test_phase_slew_ctrl;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] phaseErr = '0;
  logic         evtHoldEnter = 1'b0, evtHoldExit = 1'b0, evtRefSwitch = 1'b0;
  logic         hitlessMode = 1'b0, extLoopback = 1'b0, tick = 1'b0;
  logic [1:0]   slewCode = 2'd0;
  logic [W-1:0] phaseCmd;
  logic         settled;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    modelOn = 1'b0;
  bit    tickToggle = 1'b0;

  phase_slew_ctrl #(.PHASE_W(W)) i_phase_slew_ctrl (
    .clk(clk), .rst(rst), .phaseErr(phaseErr), .evtHoldEnter(evtHoldEnter),
    .evtHoldExit(evtHoldExit), .evtRefSwitch(evtRefSwitch), .hitlessMode(hitlessMode),
    .slewCode(slewCode), .extLoopback(extLoopback), .tick(tick),
    .phaseCmd(phaseCmd), .settled(settled)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    #1;
  endtask

  // behavioural expectation built from the requirement text
  logic [W-1:0] mBo = '0, mCmd = '0;
  logic         mWalk = 1'b0;
  always @(posedge clk) begin
    logic [W-1:0] t, d;
    int mag, st;
    t   = phaseErr - mBo;
    d   = t - mCmd;
    mag = d[W-1] ? -int'($signed(d)) : int'(d);
    st  = 1 << slewCode;
    if (rst) begin
      mBo <= '0; mCmd <= '0; mWalk <= 1'b0;
    end else if (evtHoldEnter || evtHoldExit || evtRefSwitch) begin
      if (hitlessMode && !extLoopback) begin mBo <= phaseErr - mCmd; mWalk <= 1'b0; end
      else begin mBo <= '0; mWalk <= 1'b1; end
    end else if (!mWalk) begin
      mCmd <= t;
    end else if (tick) begin
      if (mag <= st) begin mCmd <= t; mWalk <= 1'b0; end
      else mCmd <= d[W-1] ? mCmd - W'(st) : mCmd + W'(st);
    end
  end

  always begin
    @(posedge clk);
    #2;
    if (modelOn) begin
      chk(phaseCmd == mCmd, curReq, int'(phaseCmd), int'(mCmd));
      chk(settled == !mWalk, curReq, int'(settled), int'(!mWalk));
    end
  end

  always @(posedge clk) if (tickToggle) tick <= #1 ~tick;

  task automatic fireEvt(input int kind);
    evtHoldEnter = (kind == 0);
    evtHoldExit  = (kind == 1);
    evtRefSwitch = (kind == 2);
    nxt();
    evtHoldEnter = 1'b0; evtHoldExit = 1'b0; evtRefSwitch = 1'b0;
  endtask

  task automatic waitSettled();
    int n = 0;
    while (!settled && n < 40000) begin nxt(); n++; end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) nxt();
    chk(phaseCmd == 0, "R1", int'(phaseCmd), 0);
    chk(settled == 1, "R1", int'(settled), 1);
    rst = 1'b0;
    hitlessMode = 1'b1;
    phaseErr = 16'd50;
    nxt();
    chk(phaseCmd == 50, "R2", int'(phaseCmd), 50);

    // R3: build-out absorbs the step
    phaseErr = 16'd300;
    evtRefSwitch = 1'b1;
    nxt();
    evtRefSwitch = 1'b0;
    chk(phaseCmd == 50, "R3", int'(phaseCmd), 50);
    chk(settled == 1, "R3", int'(settled), 1);
    nxt();
    chk(phaseCmd == 50, "R3", int'(phaseCmd), 50);
    phaseErr = 16'd310;
    nxt();
    chk(phaseCmd == 60, "R3", int'(phaseCmd), 60);

    // R8: loopback forces slope mode despite hitlessMode
    extLoopback = 1'b1;
    fireEvt(0);
    extLoopback = 1'b0;
    chk(phaseCmd == 60, "R8", int'(phaseCmd), 60);
    chk(settled == 0, "R8", int'(settled), 0);
    repeat (3) nxt();
    chk(phaseCmd == 60, "R7", int'(phaseCmd), 60);
    chk(settled == 0, "R7", int'(settled), 0);
    slewCode = 2'd2;
    tick = 1'b1;
    nxt();
    chk(phaseCmd == 64, "R5", int'(phaseCmd), 64);
    n = 1;
    while (!settled && n < 1000) begin nxt(); n++; end
    chk(n == 63, "R6", n, 63);
    chk(phaseCmd == 310, "R6", int'(phaseCmd), 310);

    // R9: event in the middle of a walk
    hitlessMode = 1'b0;
    phaseErr = 16'd0;
    tick = 1'b0;
    fireEvt(1);
    chk(phaseCmd == 310, "R4", int'(phaseCmd), 310);
    chk(settled == 0, "R4", int'(settled), 0);
    slewCode = 2'd1;
    tick = 1'b1;
    repeat (10) nxt();
    chk(phaseCmd == 290, "R5", int'(phaseCmd), 290);
    phaseErr = 16'd1000;
    evtRefSwitch = 1'b1;
    nxt();
    evtRefSwitch = 1'b0;
    chk(phaseCmd == 290, "R9", int'(phaseCmd), 290);
    chk(settled == 0, "R9", int'(settled), 0);
    slewCode = 2'd3;
    n = 0;
    while (!settled && n < 1000) begin nxt(); n++; end
    chk(n == 89, "R9", n, 89);
    chk(phaseCmd == 1000, "R9", int'(phaseCmd), 1000);
    tick = 1'b0;

    // model-compared sweeps over codes, gaps, strobes and wrap
    modelOn = 1'b1;
    tickToggle = 1'b1;
    for (int code = 0; code < 4; code++) begin
      int dists[12] = '{0, 1, -1, 2, -3, 7, -8, 9, -15, 33, 16, -17};
      slewCode = 2'(code);
      for (int i = 0; i < 12; i++) begin
        curReq = (i % 2 == 0) ? "R5" : "R6";
        phaseErr = phaseCmd + W'(dists[i]);
        fireEvt(i % 3);
        waitSettled();
        nxt();
      end
      curReq = "R10";
      hitlessMode = 1'b1;
      for (int k = 0; k < 3; k++) begin
        phaseErr = phaseErr + W'(97 * (k + 1) + code);
        fireEvt(k);
        phaseErr = phaseErr - 16'd5;
        repeat (2) nxt();
      end
      hitlessMode = 1'b0;
      curReq = "R9";
      phaseErr = phaseCmd + 16'd120;
      fireEvt(2);
      repeat (5) nxt();
      phaseErr = phaseCmd - 16'd40;
      fireEvt(code % 3);
      waitSettled();
    end
    curReq = "R5";
    slewCode = 2'd3;
    for (int j = 0; j < 2; j++) begin
      phaseErr = phaseCmd + 16'd30000;
      fireEvt(j);
      waitSettled();
    end
    nxt();
    modelOn = 1'b0;
    tickToggle = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule